// File: doc/BRIEF.md
# Page Write Buffer With Timed Commit

This block is the write path between a serial-bus slave engine and a byte-wide memory array. The slave engine announces a new write command, loads the starting word address, and then hands over each received data byte. The block stores every byte in a page latch at the position given by the low bits of the shared address pointer. After each byte only the in-page bits of the pointer advance, so a long burst wraps around within the page and overwrites earlier bytes.

Nothing reaches the array until the STOP condition arrives. At STOP the write-protect input is sampled once. If protection is off and at least one data byte was received, the block enters a self-timed write cycle. During that cycle `busy_o` is high for a fixed number of clocks and the latched bytes are walked out to a synchronous RAM write port. The slave engine uses `busy_o` to withhold acknowledges, and while it is high the block ignores all command inputs. A protected write, or a STOP with no data, leaves the array untouched and produces no busy period.

Top module: `page_wr_buf`

## Requirements
- R1: After reset, `busy_o` is 0, `ptr_o` is 0 and `mem_we_o` is 0.
- R2: Each accepted data byte is stored at latch index `ptr_o[IDX_W-1:0]` (IDX_W = log2 of PAGE_BYTES, 6 by default). Only those low bits then increment, wrapping from PAGE_BYTES-1 to 0, and the upper pointer bits never change on a byte.
- R3: When more than PAGE_BYTES bytes arrive in one command, a later byte replaces the earlier byte at the same in-page index, and the array receives only the last value for each index.
- R4: No array write happens before STOP. `mem_we_o` is only ever high while `busy_o` is high.
- R5: A STOP with write-protect low, after at least one data byte, raises `busy_o` on the clock edge that samples STOP. `busy_o` then stays high for exactly WC_CYCLES consecutive cycles.
- R6: Write-protect is sampled only on the STOP cycle. If it is high there, no array write and no busy period follow. If it is low there, raising it during the busy period changes nothing.
- R7: Only latch entries filled since the most recent `cmd_start_i` are written to the array. Bytes left from an earlier command are never written again.
- R8: A STOP after a write command that carried no data byte writes nothing and gives no busy period, but the address loaded by `addr_load_i` stays in `ptr_o`.
- R9: After a write of N bytes starting at address A, `ptr_o` equals A with its low IDX_W bits replaced by (A + N) mod PAGE_BYTES. A single-byte write therefore leaves the pointer at the next location.
- R10: While `busy_o` is high, `cmd_start_i`, `addr_load_i` and `byte_valid_i` are ignored. The pointer holds, and the latch and its valid mask are unchanged.
- R11: During a commit, array addresses are the page base (upper pointer bits sampled at STOP) concatenated with the latch index. Writes go out one per cycle in ascending index order, within the first PAGE_BYTES cycles of the busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_start_i | input | 1 | Pulse: a new write command begins (clears the valid mask) |
| addr_load_i | input | 1 | Pulse: load `addr_i` into the address pointer |
| addr_i | input | ADDR_W | Starting word address |
| byte_valid_i | input | 1 | Pulse: `byte_i` holds a received data byte |
| byte_i | input | DATA_W | Data byte |
| stop_i | input | 1 | Pulse: STOP condition seen on the bus |
| wp_i | input | 1 | Write-protect level, sampled at STOP |
| busy_o | output | 1 | Self-timed write cycle in progress |
| ptr_o | output | ADDR_W | Shared address pointer |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | DATA_W | Array write data |

## Verification
The bench targets in-page wrapping. It starts a burst near the end of a page and sends more than a page of bytes. A design that carried into the upper address bits would write into the next page, and one that kept first values would commit stale bytes. It also checks write-protect at the exact STOP cycle and then toggles it during the busy period, to catch a design that samples it late or not at all. Further scenarios check that commands and bytes arriving while busy are dropped, and that a short write after a longer one commits only its own byte, which exposes a valid mask that is not cleared. A STOP with no data must keep the loaded pointer without starting a cycle, and the busy length is counted to the cycle.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int unsigned PWB_ADDR_W     = 15;
  localparam int unsigned PWB_DATA_W     = 8;
  localparam int unsigned PWB_PAGE_BYTES = 64;
  localparam int unsigned PWB_WC_CYCLES  = 250000;  // 5 ms at 50 MHz
endpackage

// File: rtl/pwb_addr_ptr.sv
module pwb_addr_ptr #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned IDX_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [ADDR_W-1:0] ptr_q;
  logic [IDX_W-1:0]  low_nxt;

  assign low_nxt = ptr_q[IDX_W-1:0] + IDX_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (load_i) ptr_q <= addr_i;
    else if (inc_i)  ptr_q <= {ptr_q[ADDR_W-1:IDX_W], low_nxt};  // wrap within page
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/pwb_page_latch.sv
module pwb_page_latch #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PAGE_BYTES = 64,
  localparam int unsigned IDX_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic [DATA_W-1:0]     data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mask_q <= '0;
    else if (clr_i) mask_q <= '0;
    else if (wr_i)  mask_q[widx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_i && !clr_i) data_q[widx_i] <= wdata_i;
  end

  assign rdata_o  = data_q[ridx_i];
  assign rvalid_o = mask_q[ridx_i];
endmodule

// File: rtl/pwb_commit_seq.sv
module pwb_commit_seq #(
  parameter int unsigned PAGE_BYTES = 64,
  parameter int unsigned WC_CYCLES  = 250000,
  localparam int unsigned IDX_W     = $clog2(PAGE_BYTES),
  localparam int unsigned CNT_W     = $clog2(WC_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic             walk_o,
  output logic [IDX_W-1:0] idx_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (cnt_q == CNT_W'(WC_CYCLES - 1)) busy_q <= 1'b0;
    end
  end

  // first PAGE_BYTES busy cycles walk the latch
  assign walk_o = busy_q && (cnt_q < CNT_W'(PAGE_BYTES));
  assign idx_o  = cnt_q[IDX_W-1:0];
  assign busy_o = busy_q;
endmodule

// File: rtl/page_wr_buf.sv
module page_wr_buf #(
  parameter int unsigned ADDR_W     = pwb_pkg::PWB_ADDR_W,
  parameter int unsigned DATA_W     = pwb_pkg::PWB_DATA_W,
  parameter int unsigned PAGE_BYTES = pwb_pkg::PWB_PAGE_BYTES,
  parameter int unsigned WC_CYCLES  = pwb_pkg::PWB_WC_CYCLES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_start_i,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_valid_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              stop_i,
  input  logic              wp_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  localparam int unsigned IDX_W  = $clog2(PAGE_BYTES);
  localparam int unsigned BASE_W = ADDR_W - IDX_W;

  logic              busy;
  logic              cmd_go, load_go, byte_go, stop_go, commit_go;
  logic              has_data_q;
  logic [BASE_W-1:0] base_q;
  logic [ADDR_W-1:0] ptr;
  logic              walk, rvalid;
  logic [IDX_W-1:0]  ridx;
  logic [DATA_W-1:0] rdata;

  // commands are dropped during the write cycle (slave does not ack)
  assign cmd_go    = cmd_start_i  && !busy;
  assign load_go   = addr_load_i  && !busy;
  assign byte_go   = byte_valid_i && !busy && !addr_load_i;
  assign stop_go   = stop_i       && !busy;
  assign commit_go = stop_go && has_data_q && !wp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      has_data_q <= 1'b0;
      base_q     <= '0;
    end else begin
      if (cmd_go || stop_go) has_data_q <= 1'b0;
      else if (byte_go)      has_data_q <= 1'b1;
      if (commit_go) base_q <= ptr[ADDR_W-1:IDX_W];
    end
  end

  pwb_addr_ptr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_go),
    .addr_i (addr_i),
    .inc_i  (byte_go),
    .ptr_o  (ptr)
  );

  pwb_page_latch #(.DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (cmd_go),
    .wr_i     (byte_go),
    .widx_i   (ptr[IDX_W-1:0]),
    .wdata_i  (byte_i),
    .ridx_i   (ridx),
    .rdata_o  (rdata),
    .rvalid_o (rvalid)
  );

  pwb_commit_seq #(.PAGE_BYTES(PAGE_BYTES), .WC_CYCLES(WC_CYCLES)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (commit_go),
    .busy_o  (busy),
    .walk_o  (walk),
    .idx_o   (ridx)
  );

  assign busy_o      = busy;
  assign ptr_o       = ptr;
  assign mem_we_o    = walk && rvalid;
  assign mem_addr_o  = {base_q, ridx};
  assign mem_wdata_o = rdata;
endmodule

// File: rtl/page_wr_buf_chk.sv
module page_wr_buf_chk #(
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned PAGE_BYTES = 64,
  parameter int unsigned WC_CYCLES  = 250000,
  localparam int unsigned IDX_W     = $clog2(PAGE_BYTES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              addr_load_i,
  input logic              byte_valid_i,
  input logic              stop_i,
  input logic              wp_i,
  input logic              has_data_q,
  input logic              busy_o,
  input logic [ADDR_W-1:0] ptr_o,
  input logic              mem_we_o
);
  logic [31:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + 32'd1;
    else             run_q <= '0;
  end

  p_no_early_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_we_o);

  p_commit_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !busy_o && !wp_i && has_data_q) |=> busy_o);

  p_busy_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_q == 32'(WC_CYCLES)));

  p_wp_no_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && wp_i && !busy_o) |=> !busy_o);

  p_no_data_no_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !has_data_q && !busy_o) |=> !busy_o);

  p_upper_fixed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && !addr_load_i && !busy_o) |=>
      (ptr_o[ADDR_W-1:IDX_W] == $past(ptr_o[ADDR_W-1:IDX_W])));

  p_ptr_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(ptr_o));
endmodule

bind page_wr_buf page_wr_buf_chk #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WC_CYCLES(WC_CYCLES)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .addr_load_i  (addr_load_i),
  .byte_valid_i (byte_valid_i),
  .stop_i       (stop_i),
  .wp_i         (wp_i),
  .has_data_q   (has_data_q),
  .busy_o       (busy_o),
  .ptr_o        (ptr_o),
  .mem_we_o     (mem_we_o)
);

// File: tb/page_wr_buf_tb_top.sv
module page_wr_buf_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 15;
  localparam int DATA_W     = 8;
  localparam int PAGE       = 64;
  localparam int WC         = 80;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cmd_start_i = 1'b0, addr_load_i = 1'b0, byte_valid_i = 1'b0;
  logic              stop_i = 1'b0, wp_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] byte_i = '0;
  logic              busy_o, mem_we_o;
  logic [ADDR_W-1:0] ptr_o, mem_addr_o;
  logic [DATA_W-1:0] mem_wdata_o;

  int errors = 0, checks = 0;
  int wr_cnt = 0, bad_order = 0;
  int arr [int];
  int prev_addr = -1;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  page_wr_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE), .WC_CYCLES(WC)) dut_i (
    .clk_i, .rst_ni, .cmd_start_i, .addr_load_i, .addr_i, .byte_valid_i, .byte_i,
    .stop_i, .wp_i, .busy_o, .ptr_o, .mem_we_o, .mem_addr_o, .mem_wdata_o
  );

  // array model fed by the write port, sampled mid-cycle
  always @(negedge clk_i) begin
    if (mem_we_o) begin
      arr[int'(mem_addr_o)] = int'(mem_wdata_o);
      wr_cnt++;
      if (prev_addr >= 0 && int'(mem_addr_o) <= prev_addr) bad_order++;
      prev_addr = int'(mem_addr_o);
    end
    if (!busy_o) prev_addr = -1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk_i); endtask
  task automatic p_cmd(); cmd_start_i = 1; step(); cmd_start_i = 0; endtask
  task automatic p_addr(input int a); addr_i = ADDR_W'(a); addr_load_i = 1; step(); addr_load_i = 0; endtask
  task automatic p_byte(input int b); byte_i = DATA_W'(b); byte_valid_i = 1; step(); byte_valid_i = 0; endtask
  task automatic p_stop(); stop_i = 1; step(); stop_i = 0; endtask
  task automatic wait_idle(output int n);
    n = 0;
    while (busy_o && n < 100000) begin n++; step(); end
  endtask
  function automatic int rd(input int a); return arr.exists(a) ? arr[a] : -1; endfunction

  task automatic t_reset();
    chk(busy_o == 0, "R1 busy", int'(busy_o), 0);
    chk(ptr_o == 0, "R1 ptr", int'(ptr_o), 0);
    chk(mem_we_o == 0 && wr_cnt == 0, "R1 we", wr_cnt, 0);
  endtask

  task automatic t_single();
    int n, w0;
    w0 = wr_cnt;
    p_cmd(); p_addr('h1234); p_byte('hA5);
    repeat (5) step();
    chk(wr_cnt == w0 && !busy_o, "R4 no write before stop", wr_cnt - w0, 0);
    p_stop();
    chk(busy_o == 1, "R5 busy after stop", int'(busy_o), 1);
    wait_idle(n);
    chk(n == WC, "R5 busy length", n, WC);
    chk(rd('h1234) == 'hA5, "R11 single byte", rd('h1234), 'hA5);
    chk(wr_cnt - w0 == 1, "R7 one write", wr_cnt - w0, 1);
    chk(ptr_o == 'h1235, "R9 ptr after single", int'(ptr_o), 'h1235);
  endtask

  task automatic t_page_wrap();
    int n, w0;
    w0 = wr_cnt;
    p_cmd(); p_addr('h2030);
    for (int i = 0; i < 20; i++) p_byte('h40 + i);
    chk(ptr_o == 'h2004, "R2/R9 ptr wraps in page", int'(ptr_o), 'h2004);
    p_stop(); wait_idle(n);
    for (int i = 0; i < 20; i++) begin
      int a = 'h2000 + (('h30 + i) % PAGE);
      chk(rd(a) == 'h40 + i, "R2 wrapped byte", rd(a), 'h40 + i);
    end
    chk(!arr.exists('h2040), "R2 no carry into next page", rd('h2040), -1);
    chk(wr_cnt - w0 == 20, "R11 write count", wr_cnt - w0, 20);
    chk(bad_order == 0, "R11 ascending order", bad_order, 0);
  endtask

  task automatic t_overflow();
    int n, w0;
    w0 = wr_cnt;
    p_cmd(); p_addr('h0100);
    for (int i = 0; i < 70; i++) p_byte(i);
    p_stop(); wait_idle(n);
    chk(wr_cnt - w0 == PAGE, "R3 one write per index", wr_cnt - w0, PAGE);
    for (int i = 0; i < 6; i++)
      chk(rd('h0100 + i) == 64 + i, "R3 last value wins", rd('h0100 + i), 64 + i);
    chk(rd('h0106) == 6, "R3 untouched index", rd('h0106), 6);
    chk(ptr_o == 'h0106, "R9 ptr after overflow", int'(ptr_o), 'h0106);
  endtask

  task automatic t_wp();
    int n, w0;
    w0 = wr_cnt;
    p_cmd(); p_addr('h0500); p_byte(1); p_byte(2); p_byte(3);
    wp_i = 1; p_stop();
    chk(busy_o == 0, "R6 protected no busy", int'(busy_o), 0);
    wp_i = 0; repeat (WC + 5) step();
    chk(wr_cnt == w0 && !arr.exists('h0500), "R6 protected no write", wr_cnt - w0, 0);
    p_cmd(); p_addr('h0510); p_byte('h77); p_byte('h78);
    p_stop(); wp_i = 1;
    wait_idle(n); wp_i = 0;
    chk(n == WC, "R6 late wp keeps cycle", n, WC);
    chk(rd('h0511) == 'h78, "R6 late wp still writes", rd('h0511), 'h78);
  endtask

  task automatic t_nodata();
    int w0;
    w0 = wr_cnt;
    p_cmd(); p_addr('h0777); p_stop();
    chk(busy_o == 0, "R8 no busy", int'(busy_o), 0);
    repeat (PAGE + 4) step();
    chk(wr_cnt == w0, "R8 no write", wr_cnt - w0, 0);
    chk(ptr_o == 'h0777, "R8 ptr kept", int'(ptr_o), 'h0777);
  endtask

  task automatic t_mask();
    int n, w0;
    p_cmd(); p_addr('h0600);
    for (int i = 0; i < 4; i++) p_byte('h10 + i);
    p_stop(); wait_idle(n);
    w0 = wr_cnt;
    p_cmd(); p_addr('h0602); p_byte('hC3); p_stop(); wait_idle(n);
    chk(wr_cnt - w0 == 1, "R7 only new byte", wr_cnt - w0, 1);
    chk(rd('h0602) == 'hC3, "R7 new value", rd('h0602), 'hC3);
    chk(rd('h0600) == 'h10, "R7 old byte kept", rd('h0600), 'h10);
  endtask

  task automatic t_busy_ignore();
    int n, w0;
    p_cmd(); p_addr('h0900); p_byte('h5A); p_stop();
    p_cmd(); p_addr('h7000); p_byte('hEE);
    chk(ptr_o == 'h0901, "R10 ptr holds while busy", int'(ptr_o), 'h0901);
    wait_idle(n);
    w0 = wr_cnt;
    p_cmd(); p_addr('h0800); p_byte('h33); p_stop(); wait_idle(n);
    chk(wr_cnt - w0 == 1, "R10 ignored byte not latched", wr_cnt - w0, 1);
    chk(!arr.exists('h7000), "R10 no write at ignored addr", rd('h7000), -1);
    chk(rd('h0800) == 'h33, "R10 next write ok", rd('h0800), 'h33);
  endtask

  initial begin
    repeat (3) step();
    rst_ni = 1;
    step();
    t_reset();
    t_single();
    t_page_wrap();
    t_overflow();
    t_wp();
    t_nodata();
    t_mask();
    t_busy_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule